// File: doc/BRIEF.md
# CPU Wait-State Injector

This block generates the clock-enable that lets a CPU core advance while it accesses a video controller. When `cpu_en` is low, the core must hold all of its state. That includes its bus outputs, so the access it is attempting stays on the bus until it completes. Two sources can hold the core.

The first source is a level-sensitive not-ready signal from the video controller's slot scheduler. It keeps the core frozen for as many cycles as the scheduler needs. The second source is a fixed one-cycle penalty for accesses to the lowest register window of the video controller.

The penalty is tracked with a one-shot flag. The flag is set when the penalty is taken and cleared as soon as the enable returns. As a result, the penalty never depends on core state, which is frozen during the stall. Every new bus cycle re-arms the penalty, so the read phase and the write phase of a read-modify-write instruction each pay it. Accesses made by the dedicated immediate-store opcodes never pay it.

When both sources overlap, the freeze lasts until the later of the two releases. The two are not added together.

Top module: `cpu_wait_gen`

## Requirements
- R1: When no video access is in progress, `cpu_en` is 1. A video access is `cyc_stb`=1 with `vid_sel`=1.
- R2: During a video access, `cpu_en` is 0 in every cycle in which `slot_rdy` is 0.
- R3: A video access to an address below REG_COUNT (default 16, so 0x0000–0x000F) with `imm_store`=0 and `slot_rdy`=1 costs exactly one cycle with `cpu_en`=0.
- R4: A video access with `imm_store`=1 takes no penalty, even at an address below REG_COUNT.
- R5: A video access at an address of REG_COUNT or above takes no penalty when `slot_rdy`=1.
- R6: In a read-modify-write to a low register, the read phase and the write phase are separate bus cycles, and each takes one penalty cycle.
- R7: When the not-ready stall and the penalty overlap, the number of wait cycles is the larger of the two (N not-ready cycles, or 1), not their sum.
- R8: While `rst_n`=0, `cpu_en` is 1. Reset clears any pending penalty state, so the first low-register access after reset takes its penalty.
- R9: The penalty flag clears when the enable returns, so consecutive low-register accesses each take a penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_stb | input | 1 | The core is attempting a bus cycle |
| vid_sel | input | 1 | The bus cycle targets the video controller |
| addr | input | ADDR_W | Address of the bus cycle |
| imm_store | input | 1 | The bus cycle belongs to an immediate-store opcode |
| slot_rdy | input | 1 | Scheduler ready; 0 requests a stall |
| cpu_en | output | 1 | Core clock-enable; 0 freezes the core |

## Verification
The hardest case to reach is an overlap in which the penalty has already been taken while the scheduler is still holding the core. In that case the flag must survive the remaining not-ready cycles without adding another wait cycle. The bench reaches this case with a model of the core that holds its bus cycle until it sees the enable, while `slot_rdy` is held low for a chosen number of cycles. The bench also covers reset arriving in the middle of a penalty, and two back-to-back phases at the same address with no idle cycle between them.

// File: rtl/cpu_wait_gen.sv
module cpu_wait_gen #(
  parameter int ADDR_W    = 16,
  parameter int REG_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic              vid_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              imm_store,
  input  logic              slot_rdy,
  output logic              cpu_en
);
  localparam int REG_BITS = $clog2(REG_COUNT);

  logic vid_req, reg_hit, pen_taken, pen_wait, rdy_wait;

  assign vid_req  = cyc_stb & vid_sel;
  assign reg_hit  = (addr[ADDR_W-1:REG_BITS] == '0);
  assign pen_wait = vid_req & reg_hit & ~imm_store & ~pen_taken;
  assign rdy_wait = vid_req & ~slot_rdy;
  assign cpu_en   = ~rst_n | ~(pen_wait | rdy_wait);

  always_ff @(posedge clk) begin
    if (!rst_n)        pen_taken <= 1'b0;
    else if (cpu_en)   pen_taken <= 1'b0;
    else if (pen_wait) pen_taken <= 1'b1;
  end

  always_comb begin
    a_reset_run_r8: assert (rst_n || cpu_en);
  end

  p_idle_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_req |-> cpu_en);
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && !slot_rdy) |-> !cpu_en);
  p_no_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && !cpu_en && slot_rdy) |=> (cpu_en || !slot_rdy || !vid_req));
  p_imm_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && imm_store && slot_rdy) |-> cpu_en);
  p_high_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && !reg_hit && slot_rdy) |-> cpu_en);
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |=> !pen_taken);
endmodule

// File: tb/cpu_wait_gen_test.sv
module cpu_wait_gen_test;
  logic clk = 0, rst_n = 0;
  logic cyc_stb = 0, vid_sel = 0, imm_store = 0, slot_rdy = 1;
  logic [15:0] addr = '0;
  logic cpu_en;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cpu_wait_gen uut (.clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .vid_sel(vid_sel),
    .addr(addr), .imm_store(imm_store), .slot_rdy(slot_rdy), .cpu_en(cpu_en));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic im, input int nbusy, output int waits);
    int cyc = 0;
    waits = 0;
    while (cyc < 60) begin
      @(negedge clk);
      cyc_stb = 1; vid_sel = 1; addr = a; imm_store = im;
      slot_rdy = (cyc >= nbusy);
      #1;
      if (cpu_en) break;
      waits++; cyc++;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cyc_stb = 0; vid_sel = 0; slot_rdy = 1; imm_store = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    cyc_stb = 1; vid_sel = 1; addr = 16'h0; slot_rdy = 0; #1;
    check("R8 enable high in reset", cpu_en, 1);
    idle(); rst_n = 1; #1;
    check("R1 idle after reset", cpu_en, 1);
  endtask

  task automatic t_nonvideo();
    @(negedge clk);
    cyc_stb = 1; vid_sel = 0; addr = 16'h0; slot_rdy = 0; #1;
    check("R1 non-video access", cpu_en, 1);
    idle();
  endtask

  task automatic t_penalty();
    int w;
    access(16'h0000, 0, 0, w); check("R3 addr 0x0000", w, 1); idle();
    access(16'h000F, 0, 0, w); check("R3 addr 0x000F", w, 1); idle();
    access(16'h0010, 0, 0, w); check("R5 addr 0x0010", w, 0); idle();
    access(16'h8100, 0, 0, w); check("R5 addr 0x8100", w, 0); idle();
    access(16'h0002, 1, 0, w); check("R4 immediate store", w, 0); idle();
  endtask

  task automatic t_busy();
    int w;
    access(16'h0020, 0, 3, w); check("R2 stall 3 high addr", w, 3); idle();
    access(16'h0020, 0, 1, w); check("R2 stall 1 high addr", w, 1); idle();
    access(16'h0002, 1, 2, w); check("R2 stall 2 immediate", w, 2); idle();
  endtask

  task automatic t_overlap();
    int w;
    access(16'h0003, 0, 4, w); check("R7 overlap 4 vs 1", w, 4); idle();
    access(16'h0003, 0, 1, w); check("R7 overlap 1 vs 1", w, 1); idle();
  endtask

  task automatic t_rmw();
    int w1, w2;
    access(16'h0003, 0, 0, w1);
    access(16'h0003, 0, 0, w2);
    check("R6 read phase", w1, 1);
    check("R6 write phase", w2, 1);
    idle();
    access(16'h0001, 0, 0, w1);
    access(16'h0005, 0, 0, w2);
    check("R9 second consecutive access", w2, 1);
    idle();
    access(16'h0040, 0, 0, w1);
    access(16'h0040, 0, 0, w2);
    check("R5 back-to-back high", w1 + w2, 0);
    idle();
  endtask

  task automatic t_reset_mid();
    int w;
    @(negedge clk);
    cyc_stb = 1; vid_sel = 1; addr = 16'h0004; imm_store = 0; slot_rdy = 1; #1;
    check("R3 frozen first cycle", cpu_en, 0);
    @(negedge clk); rst_n = 0; #1;
    check("R8 enable high on mid reset", cpu_en, 1);
    idle(); rst_n = 1;
    access(16'h0004, 0, 0, w); check("R8 penalty after reset", w, 1); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_nonvideo();
    t_penalty();
    t_busy();
    t_overlap();
    t_rmw();
    t_reset_mid();
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule